// File: doc/BRIEF.md
# Strobed Byte-Bus Register Target

This block is the peripheral end of a byte-wide parallel bus on which address and data share the same eight lines. The master marks each byte with a rising strobe. An address-latch flag is sampled at that edge and says whether the byte is a register address or part of a value. A direction line sets whether the target drives the bus (read) or samples it (write). Each 16-bit value moves as two bytes, the most significant byte first. A rising chip-select closes the transfer.

All bus inputs are brought into the local clock domain through a synchronizer chain, and edges are found there. The block holds a bank of 16-bit registers that the local logic can see in parallel. A busy input from the local logic turns the ready reply at the end of a transfer into a retry request. For a write, the master then pulses chip-select again and the held value is committed once busy has cleared. For a read, the master repeats both value bytes from the top.

Top module: `strobed_reg_target`

## Requirements
- R1: After reset, every register reads zero, the data output enable is low and ready is low.
- R2: A strobe rising edge with the address-latch flag high takes the bus byte as the register address and restarts value-byte counting, so the next value byte is treated as the most significant one.
- R3: On a write (direction high), the first value byte is bits 15:8 and the second is bits 7:0. The register changes only at the chip-select rise that follows both bytes, and not before.
- R4: On a read (direction low), the first value byte phase drives bits 15:8 of the addressed register on the data output with the output enable high, and the second phase drives bits 7:0.
- R5: The data output enable stays low during address phases and during every write phase.
- R6: At a chip-select rise after two value bytes, ready becomes the value of the busy input. A write seen with busy high is held, not applied. A later chip-select rise with busy low applies it and returns ready low.
- R7: After a read answered with ready high, the next two value bytes are served again starting with bits 15:8, with no new address phase.
- R8: An address at or above the register count reads as 0x0000, and a write to it changes no register.
- R9: A chip-select rise after fewer than two value bytes changes neither the registers nor ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_strobe | input | 1 | Byte strobe; a rising edge marks a byte phase |
| pin_latch | input | 1 | High at the strobe edge marks an address byte |
| pin_sel | input | 1 | Chip-select; a rising edge closes the transfer |
| pin_dir | input | 1 | 1 = write (target samples), 0 = read (target drives) |
| pin_data_in | input | 8 | Byte from the master |
| pin_data_out | output | 8 | Byte returned on reads |
| pin_data_oe | output | 1 | Target drives the data bus when high |
| pin_ready | output | 1 | Transfer-end reply: 0 = done, 1 = retry |
| loc_busy | input | 1 | Local logic requests a retry |
| loc_regs | output | NUM_REGS*16 | Register bank, register i at bits 16*i+15:16*i |

## Verification
Directed transfers use values whose high and low bytes differ, such as 0x1234, so that swapped byte order shows at once. Out-of-range addresses separate real storage from the zero read-back. Busy writes and busy reads show apart the two retry styles: a write re-commits on a bare chip-select pulse, while a read restarts from the high byte. A transfer closed after a single value byte shows that a partial transfer has no effect. Seeded random transfers then mix addresses inside and outside the bank, both directions and random busy, and compare against a bench model of the registers.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic              strobe;
        logic              latch;
        logic              sel;
        logic              dir;
        logic [BYTE_W-1:0] data;
    } bus_sig_t;

    typedef enum logic [1:0] {
        VB_NONE = 2'd0,
        VB_HI   = 2'd1,
        VB_BOTH = 2'd2
    } vbyte_cnt_t;

    function automatic logic [BYTE_W-1:0] word_byte(input logic [WORD_W-1:0] w,
                                                    input logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/sbt_sync.sv
module sbt_sync #(
    parameter int W     = 12,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
    import sbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_sig_t          cur,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [BYTE_W-1:0] addr,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word,
    output logic [BYTE_W-1:0] dout,
    output logic              oe,
    output logic              ready
);
    logic       strobe_d, sel_d;
    logic       stb_rise, stb_fall, sel_rise;
    vbyte_cnt_t cnt;
    logic [BYTE_W-1:0] hi_q, lo_q;

    assign stb_rise = cur.strobe & ~strobe_d;
    assign stb_fall = ~cur.strobe & strobe_d;
    assign sel_rise = cur.sel & ~sel_d;
    assign wr_en    = sel_rise & (cnt == VB_BOTH) & cur.dir & ~busy;
    assign wr_word  = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b0;
            sel_d    <= 1'b0;
            cnt      <= VB_NONE;
            addr     <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            dout     <= '0;
            oe       <= 1'b0;
            ready    <= 1'b0;
        end else begin
            strobe_d <= cur.strobe;
            sel_d    <= cur.sel;
            if (stb_rise) begin
                if (cur.latch) begin
                    addr <= cur.data;
                    cnt  <= VB_NONE;
                    oe   <= 1'b0;
                end else begin
                    case (cnt)
                        VB_NONE: begin
                            if (cur.dir) hi_q <= cur.data;
                            else         dout <= word_byte(rd_word, 1'b1);
                            oe  <= ~cur.dir;
                            cnt <= VB_HI;
                        end
                        VB_HI: begin
                            if (cur.dir) lo_q <= cur.data;
                            else         dout <= word_byte(rd_word, 1'b0);
                            oe  <= ~cur.dir;
                            cnt <= VB_BOTH;
                        end
                        default: oe <= 1'b0;
                    endcase
                end
            end else if (stb_fall) begin
                oe <= 1'b0;
            end
            if (sel_rise && cnt == VB_BOTH) begin
                ready <= busy;
                oe    <= 1'b0;
                if (!cur.dir) cnt <= VB_NONE;
            end
        end
    end

    // R2
    addr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && cur.latch) |=> (cnt == VB_NONE && !oe));
    // R5
    oe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        oe |-> (cnt != VB_NONE));
    // R6
    busy_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && cnt == VB_BOTH && busy) |=> ready);
    // R6
    wr_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !ready);
endmodule

// File: rtl/sbt_bank.sv
module sbt_bank
    import sbt_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [BYTE_W-1:0]          rd_addr,
    output logic [WORD_W-1:0]          rd_data,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [WORD_W-1:0] mem [NUM_REGS];
    logic              rd_hit;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (wr_en && wr_addr == BYTE_W'(g))
                    mem[g] <= wr_data;
            end
            assign regs_flat[g*WORD_W +: WORD_W] = mem[g];
        end
    endgenerate

    assign rd_hit  = ({1'b0, rd_addr} < (BYTE_W+1)'(NUM_REGS));
    assign rd_data = rd_hit ? mem[rd_addr[IDX_W-1:0]] : '0;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat));
    // R8
    oor_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ({1'b0, wr_addr} >= (BYTE_W+1)'(NUM_REGS))) |=> $stable(regs_flat));
endmodule

// File: rtl/strobed_reg_target.sv
module strobed_reg_target
    import sbt_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pin_strobe,
    input  logic                       pin_latch,
    input  logic                       pin_sel,
    input  logic                       pin_dir,
    input  logic [7:0]                 pin_data_in,
    output logic [7:0]                 pin_data_out,
    output logic                       pin_data_oe,
    output logic                       pin_ready,
    input  logic                       loc_busy,
    output logic [NUM_REGS*16-1:0]     loc_regs
);
    localparam int SIG_W = $bits(bus_sig_t);

    bus_sig_t          raw, synced;
    logic [BYTE_W-1:0] addr;
    logic              wr_en;
    logic [WORD_W-1:0] wr_word, rd_word;

    assign raw = '{strobe: pin_strobe, latch: pin_latch, sel: pin_sel,
                   dir: pin_dir, data: pin_data_in};

    sbt_sync #(.W(SIG_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    sbt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cur     (synced),
        .busy    (loc_busy),
        .rd_word (rd_word),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .dout    (pin_data_out),
        .oe      (pin_data_oe),
        .ready   (pin_ready)
    );

    sbt_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (addr),
        .wr_data   (wr_word),
        .rd_addr   (addr),
        .rd_data   (rd_word),
        .regs_flat (loc_regs)
    );
endmodule

// File: tb/tb_strobed_reg_target.sv
module tb_strobed_reg_target;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS      = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_strobe = 0, pin_latch = 0, pin_sel = 0, pin_dir = 0, loc_busy = 0;
    logic [7:0] pin_data_in = 8'h00;
    logic [7:0] pin_data_out;
    logic pin_data_oe, pin_ready;
    logic [NREGS*16-1:0] loc_regs;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [NREGS];
    logic [7:0]  got_byte;
    logic        got_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobed_reg_target #(.NUM_REGS(NREGS)) dut (
        .clk(clk), .rst(rst),
        .pin_strobe(pin_strobe), .pin_latch(pin_latch), .pin_sel(pin_sel),
        .pin_dir(pin_dir), .pin_data_in(pin_data_in),
        .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
        .pin_ready(pin_ready), .loc_busy(loc_busy), .loc_regs(loc_regs)
    );

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        return (a < NREGS) ? model[a[2:0]] : 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        logic ok = 1'b1;
        for (int i = 0; i < NREGS; i++)
            if (loc_regs[i*16 +: 16] !== model[i]) ok = 1'b0;
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected bank mismatch", req, loc_regs);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic phase(input logic latch, input logic [7:0] b);
        pin_strobe  = 1'b0;
        pin_sel     = 1'b0;
        pin_latch   = latch;
        pin_data_in = b;
        wait_n(4);
        pin_strobe = 1'b1;
        wait_n(6);
        got_oe   = pin_data_oe;
        got_byte = pin_data_out;
        pin_strobe = 1'b0;
        pin_latch  = 1'b0;
        wait_n(4);
    endtask

    task automatic sel_pulse();
        pin_sel = 1'b0;
        wait_n(4);
        pin_sel = 1'b1;
        wait_n(6);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] v, input logic busy);
        pin_dir = 1'b1;
        phase(1'b1, a);
        chk("R5 oe in write address phase", got_oe, 0);
        phase(1'b0, v[15:8]);
        chk("R5 oe in write value phase", got_oe, 0);
        phase(1'b0, v[7:0]);
        chk_bank("R3 no update before chip-select");
        loc_busy = busy;
        sel_pulse();
        chk("R6 ready after write", pin_ready, busy);
        if (busy) begin
            chk_bank("R6 busy write held");
            loc_busy = 1'b0;
            sel_pulse();
            chk("R6 ready after write retry", pin_ready, 0);
        end
        loc_busy = 1'b0;
        if (a < NREGS) model[a[2:0]] = v;
        chk_bank("R3 R8 bank after write");
    endtask

    task automatic read_pair(input logic [7:0] a, input string req);
        logic [15:0] e = exp_read(a);
        phase(1'b0, 8'h00);
        chk({req, " oe high byte"}, got_oe, 1);
        chk({req, " high byte"}, got_byte, e[15:8]);
        phase(1'b0, 8'h00);
        chk({req, " low byte"}, got_byte, e[7:0]);
    endtask

    task automatic do_read(input logic [7:0] a, input logic busy);
        pin_dir = 1'b0;
        phase(1'b1, a);
        chk("R5 oe in read address phase", got_oe, 0);
        read_pair(a, (a < NREGS) ? "R4" : "R8");
        loc_busy = busy;
        sel_pulse();
        chk("R6 ready after read", pin_ready, busy);
        loc_busy = 1'b0;
        if (busy) begin
            read_pair(a, "R7 retry");
            sel_pulse();
            chk("R7 ready after read retry", pin_ready, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic prev_ready;
        void'($urandom(32'd1357));
        for (int i = 0; i < NREGS; i++) model[i] = 16'h0000;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R1
        chk("R1 ready at reset", pin_ready, 0);
        chk("R1 oe at reset", pin_data_oe, 0);
        chk_bank("R1 bank at reset");

        do_write(8'd2, 16'h1234, 1'b0);
        do_read(8'd2, 1'b0);
        do_write(8'd7, 16'hA55A, 1'b0);
        do_read(8'd7, 1'b0);
        // R8
        do_write(8'd200, 16'hBEEF, 1'b0);
        do_read(8'd200, 1'b0);
        do_read(8'd8, 1'b0);
        // R6 / R7
        do_write(8'd5, 16'hC3F0, 1'b1);
        do_read(8'd5, 1'b1);
        // R2: a second address phase restarts counting
        pin_dir = 1'b0;
        phase(1'b1, 8'd7);
        phase(1'b0, 8'h00);
        phase(1'b1, 8'd2);
        read_pair(8'd2, "R2 restart");
        sel_pulse();
        // R9: transfer closed after one value byte
        prev_ready = pin_ready;
        pin_dir = 1'b1;
        phase(1'b1, 8'd3);
        phase(1'b0, 8'hAA);
        loc_busy = 1'b1;
        sel_pulse();
        loc_busy = 1'b0;
        chk("R9 ready unchanged", pin_ready, prev_ready);
        chk_bank("R9 bank unchanged");

        for (int n = 0; n < 40; n++) begin
            logic [7:0]  a = 8'($urandom_range(0, NREGS + 3));
            logic [15:0] v = 16'($urandom);
            logic        b = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 1) do_write(a, v, b);
            else                           do_read(a, b);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule